// File: doc/BRIEF.md
# Snoop Phase Completion Resolver

This block looks at the snoop results for the transaction at the head of the in-order queue and decides how that transaction completes. A single snoop-valid clock samples the active-low modified-hit and defer inputs together with a static policy bit. The block then resolves one of four completion types and holds it until the response logic acknowledges it.

When the type is implicit writeback, the block also tracks the handshake that comes before the writeback data phase. If the transaction has a write portion, the target-ready handshake for that portion must assert and then release first. After that, the memory agent's own target-ready assertion must be seen. The snooper then raises data-busy, and the block asserts the implicit-writeback response strobe combinationally on exactly that clock, for one clock only. The block does not drive data, encode the response pins or issue the deferred reply.

Top module: `snoop_resolver`

## Requirements
- R1: After reset, `cpl_vld_o` and `iwb_rsp_o` are 0.
- R2: With `hit_mod_ni` and `defer_ni` both low at the sample, the resolved type is implicit writeback (code 2'b01).
- R3: With `defer_ni` low and `hit_mod_ni` high, the type is retry (2'b11) when `retry_pol_i` is 1 and deferred (2'b10) when it is 0.
- R4: With both snoop inputs high, the type is normal (2'b00).
- R5: With only `hit_mod_ni` low, the type is implicit writeback (2'b01), whatever the policy bit.
- R6: A sample sets `cpl_vld_o` on the next clock. `cpl_type_o` then stays stable until `ack_i` is high on a clock, after which `cpl_vld_o` is 0.
- R7: A `snoop_vld_i` pulse while a result is held does not change the held type.
- R8: For implicit writeback, `iwb_rsp_o` stays low until a target-ready assertion has been seen after the head transaction was resolved. When `wr_phase_i` was high at the sample, the target-ready assertion and release of the write portion do not count. Data-busy seen before the counted target-ready does not fire the strobe.
- R9: After the counted target-ready, `iwb_rsp_o` is high in exactly the first clock with `dbsy_ni` low, and low on every clock after it.
- R10: `iwb_rsp_o` never asserts for a normal, deferred or retry completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snoop_vld_i | input | 1 | Snoop results valid this clock |
| hit_mod_ni | input | 1 | Modified hit, active low |
| defer_ni | input | 1 | Defer, active low |
| retry_pol_i | input | 1 | 1 selects retry, 0 selects deferred |
| wr_phase_i | input | 1 | Transaction has a write portion |
| trdy_ni | input | 1 | Target ready, active low |
| dbsy_ni | input | 1 | Snooper data busy, active low |
| ack_i | input | 1 | Clears the held completion |
| cpl_vld_o | output | 1 | Completion type held |
| cpl_type_o | output | 2 | 00 normal, 01 implicit writeback, 10 deferred, 11 retry |
| iwb_rsp_o | output | 1 | Implicit-writeback response strobe |

## Verification
A table drives all eight combinations of modified-hit, defer and policy. It shows that modified-hit takes priority over defer, that the policy bit only matters when defer alone is active, and that the normal type appears only when both snoop inputs are inactive.

Directed handshake sequences check the strobe timing. One sequence raises data-busy early, to tell a premature strobe apart from a correct one. Another includes a write portion, to tell the write target-ready apart from the writeback target-ready. Holding data-busy low for an extra clock shows that the strobe lasts one clock. A repeated snoop pulse while a result is held, and a handshake under a deferred result, confirm that neither one leaks into the outputs.

// File: rtl/snoop_resolver_pkg.sv
package snoop_resolver_pkg;
  localparam int unsigned CPL_W = 2;

  typedef enum logic [CPL_W-1:0] {
    CPL_NORMAL = 2'b00,
    CPL_IWB    = 2'b01,
    CPL_DEFER  = 2'b10,
    CPL_RETRY  = 2'b11
  } cpl_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WR_TRDY,
    SQ_WR_REL,
    SQ_IWB_TRDY,
    SQ_IWB_DBSY,
    SQ_DONE
  } seq_e;
endpackage

// File: rtl/snoop_decode.sv
module snoop_decode
  import snoop_resolver_pkg::*;
(
  input  logic hit_mod_ni,
  input  logic defer_ni,
  input  logic retry_pol_i,
  output cpl_e cpl_o
);
  // modified hit has priority over defer
  always_comb begin
    if (!hit_mod_ni)    cpl_o = CPL_IWB;
    else if (!defer_ni) cpl_o = retry_pol_i ? CPL_RETRY : CPL_DEFER;
    else                cpl_o = CPL_NORMAL;
  end
endmodule

// File: rtl/cpl_hold.sv
module cpl_hold
  import snoop_resolver_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clear_i,
  input  cpl_e cpl_i,
  output logic vld_o,
  output cpl_e cpl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      cpl_o <= CPL_NORMAL;
    end else if (clear_i) begin
      vld_o <= 1'b0;
    end else if (load_i) begin
      vld_o <= 1'b1;
      cpl_o <= cpl_i;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !clear_i |=> vld_o && $stable(cpl_o)); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !vld_o); // R6
endmodule

// File: rtl/iwb_seq.sv
module iwb_seq
  import snoop_resolver_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wr_phase_i,
  input  logic clear_i,
  input  logic trdy_ni,
  input  logic dbsy_ni,
  output logic rsp_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:     if (start_i) state_d = wr_phase_i ? SQ_WR_TRDY : SQ_IWB_TRDY;
      SQ_WR_TRDY:  if (!trdy_ni) state_d = SQ_WR_REL;
      SQ_WR_REL:   if (trdy_ni)  state_d = SQ_IWB_TRDY;
      SQ_IWB_TRDY: if (!trdy_ni) state_d = SQ_IWB_DBSY;
      SQ_IWB_DBSY: if (!dbsy_ni) state_d = SQ_DONE;
      SQ_DONE:     state_d = SQ_DONE;
      default:     state_d = SQ_IDLE;
    endcase
    if (clear_i) state_d = SQ_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  // response coincides with the first data-busy clock
  assign rsp_o = (state_q == SQ_IWB_DBSY) && !dbsy_ni;

  AST_NO_RSP_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !rsp_o); // R8
  AST_RSP_NEEDS_DBSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_o |-> !dbsy_ni); // R9
  AST_RSP_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_o |=> !rsp_o); // R9
endmodule

// File: rtl/snoop_resolver.sv
module snoop_resolver
  import snoop_resolver_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snoop_vld_i,
  input  logic             hit_mod_ni,
  input  logic             defer_ni,
  input  logic             retry_pol_i,
  input  logic             wr_phase_i,
  input  logic             trdy_ni,
  input  logic             dbsy_ni,
  input  logic             ack_i,
  output logic             cpl_vld_o,
  output logic [CPL_W-1:0] cpl_type_o,
  output logic             iwb_rsp_o
);
  cpl_e dec_cpl, held_cpl;
  logic load, clear;

  snoop_decode i_decode (
    .hit_mod_ni (hit_mod_ni),
    .defer_ni   (defer_ni),
    .retry_pol_i(retry_pol_i),
    .cpl_o      (dec_cpl)
  );

  // samples taken only while nothing is held
  assign load  = snoop_vld_i && !cpl_vld_o;
  assign clear = ack_i && cpl_vld_o;

  cpl_hold i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .clear_i(clear),
    .cpl_i  (dec_cpl),
    .vld_o  (cpl_vld_o),
    .cpl_o  (held_cpl)
  );

  assign cpl_type_o = held_cpl;

  iwb_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (load && dec_cpl == CPL_IWB),
    .wr_phase_i(wr_phase_i),
    .clear_i   (clear),
    .trdy_ni   (trdy_ni),
    .dbsy_ni   (dbsy_ni),
    .rsp_o     (iwb_rsp_o)
  );

  AST_RSP_ONLY_IWB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iwb_rsp_o |-> cpl_vld_o && cpl_type_o == CPL_IWB); // R10
  AST_HIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && !hit_mod_ni |=> cpl_type_o == CPL_IWB); // R2
  AST_DEFER_POLICY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && hit_mod_ni && !defer_ni |=> cpl_type_o[1]); // R3
  AST_HELD_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_vld_o && !ack_i && snoop_vld_i |=> $stable(cpl_type_o)); // R7
endmodule

// File: tb/test_snoop_resolver.sv
module test_snoop_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snoop_vld = 1'b0, hit_n = 1'b1, def_n = 1'b1, pol = 1'b0, wr = 1'b0;
  logic trdy_n = 1'b1, dbsy_n = 1'b1, ack = 1'b0;
  logic vld, rsp;
  logic [1:0] typ;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  snoop_resolver i_snoop_resolver (
    .clk_i(clk), .rst_ni(rst_n), .snoop_vld_i(snoop_vld), .hit_mod_ni(hit_n),
    .defer_ni(def_n), .retry_pol_i(pol), .wr_phase_i(wr), .trdy_ni(trdy_n),
    .dbsy_ni(dbsy_n), .ack_i(ack), .cpl_vld_o(vld), .cpl_type_o(typ),
    .iwb_rsp_o(rsp)
  );

  // {hit_n, def_n, pol, expected type}
  localparam logic [4:0] VEC [8] = '{
    5'b000_01, 5'b001_01, 5'b010_01, 5'b011_01,
    5'b100_10, 5'b101_11, 5'b110_00, 5'b111_00
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(logic h, logic d, logic p, logic w);
    @(negedge clk);
    hit_n = h; def_n = d; pol = p; wr = w; snoop_vld = 1'b1;
    @(negedge clk);
    snoop_vld = 1'b0; hit_n = 1'b1; def_n = 1'b1;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // drive handshake inputs after a negedge, check strobe mid-cycle
  task automatic hs(logic t, logic b, logic exp_rsp, string req);
    @(negedge clk);
    trdy_n = t; dbsy_n = b;
    #1 chk(req, rsp, exp_rsp);
  endtask

  initial begin
    #35;
    chk("R1 vld", vld, 0);
    chk("R1 rsp", rsp, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      load(VEC[i][4], VEC[i][3], VEC[i][2], 1'b0);
      chk("R6 vld set", vld, 1);
      if (VEC[i][4:3] == 2'b00) chk("R2 both", typ, VEC[i][1:0]);
      else if (VEC[i][4:3] == 2'b01) chk("R5 hit only", typ, VEC[i][1:0]);
      else if (VEC[i][4:3] == 2'b10) chk("R3 defer only", typ, VEC[i][1:0]);
      else chk("R4 none", typ, VEC[i][1:0]);
      do_ack();
      chk("R6 ack clears", vld, 0);
    end

    // R7 held result ignores new sample; R6 stable over idle clocks
    load(1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk); hit_n = 1'b0; snoop_vld = 1'b1;
    @(negedge clk); snoop_vld = 1'b0; hit_n = 1'b1;
    chk("R7 ignored", typ, 3);
    repeat (3) @(negedge clk);
    chk("R6 stable", typ, 3);
    chk("R6 still vld", vld, 1);
    // R10 handshake under retry does nothing
    hs(1'b0, 1'b1, 1'b0, "R10 trdy");
    hs(1'b1, 1'b0, 1'b0, "R10 dbsy");
    hs(1'b1, 1'b1, 1'b0, "R10 idle");
    do_ack();

    // R8/R9 implicit writeback without write portion
    load(1'b0, 1'b1, 1'b0, 1'b0);
    hs(1'b1, 1'b0, 1'b0, "R8 early dbsy");
    hs(1'b0, 1'b1, 1'b0, "R8 trdy clock");
    hs(1'b1, 1'b0, 1'b1, "R9 strobe");
    hs(1'b1, 1'b0, 1'b0, "R9 single");
    hs(1'b1, 1'b1, 1'b0, "R9 after");
    do_ack();

    // R8/R9 with write portion
    load(1'b0, 1'b0, 1'b1, 1'b1);
    hs(1'b0, 1'b1, 1'b0, "R8 wr trdy");
    hs(1'b0, 1'b0, 1'b0, "R8 dbsy in wr");
    hs(1'b1, 1'b0, 1'b0, "R8 wr release");
    hs(1'b0, 1'b1, 1'b0, "R8 iwb trdy");
    hs(1'b1, 1'b0, 1'b1, "R9 strobe wr");
    hs(1'b1, 1'b1, 1'b0, "R9 done");
    do_ack();
    chk("R6 final clear", vld, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule